// File: doc/BRIEF.md
# DRAM Row/Column Address Multiplexing Controller

This block converts CPU bus accesses into DRAM cycles for one DRAM bank. An access is taken only when the CPU raises a request that decodes into the block's chip-select area and the access-control enable is set. The block then runs a fixed strobe sequence. It drives the row address and lowers RAS. One clock later it drives the column address and lowers the column strobes together with either the write strobe or the output enable. It holds that phase for the programmed wait states. It then releases every strobe and keeps RAS high for a precharge period before it accepts the next access.

The address is split at a programmable point, with 8 to 11 column bits. On a 16-bit data bus both the column field and the row field start one address bit higher. A 16-bit bus also replaces the single column strobe with separate lower and upper byte strobes. When multiplexing is switched off, the low twelve address bits are driven unchanged in both phases. A slow option adds one clock to the column phase and one clock to the precharge, for slower DRAM parts.

Every configuration input and every access attribute is captured when the access is accepted. Changing them during an access has no effect on that access.

Top module: `dmx_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it: `ras_n`, `cas_n`, `lcas_n`, `ucas_n`, `we_n` and `oe_n` are high, `busy` is low and `dram_a` is 0.
- R2: An access is accepted at a clock edge only when `req`, `cs_hit` and `cfg_en` are all 1 and `busy` is 0. A request that fails any of these conditions produces no strobe and leaves `busy` low.
- R3: In the cycle after acceptance, `ras_n` is low and `dram_a` carries the row address. In the next cycle `ras_n` stays low and the column strobe phase begins with `dram_a` carrying the column address. No column strobe is low while `ras_n` is high.
- R4: `cfg_col_len` values 0, 1, 2 and 3 select column lengths L of 8, 9, 10 and 11. On an 8-bit bus (`bus16`=0) the column address is addr[L-1:0], zero-extended to 12 bits. The row address is addr[L+11:L].
- R5: With `bus16`=1, the column address is addr[L:1], zero-extended. The row address is addr[L+12:L+1].
- R6: In the column phase with `bus16`=0, only `cas_n` goes low. With `bus16`=1, `cas_n` stays high, `lcas_n` is low exactly when `be_lo`=1, and `ucas_n` is low exactly when `be_hi`=1.
- R7: In the column phase, `we_n` is low for a write (`wr`=1) and `oe_n` is low for a read (`wr`=0). At all other times both are high.
- R8: The column phase lasts 1 + `wait_cnt` cycles when `cfg_slow`=0. It lasts 2 + `wait_cnt` cycles when `cfg_slow`=1.
- R9: After the column phase, every strobe is high and `busy` stays high for a precharge of 1 cycle when `cfg_slow`=0 and 2 cycles when `cfg_slow`=1. After that, `busy` falls.
- R10: With `cfg_mux_en`=0, `dram_a` equals addr[11:0] in both the row phase and the column phase. Outside these two phases, `dram_a` is 0 in every mode.
- R11: A request presented while `busy` is 1 is ignored. A request held high is taken at the first edge where `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Access-control enable |
| cfg_mux_en | input | 1 | 1: split the address into row and column; 0: pass it through |
| cfg_col_len | input | 2 | Column length code (8 + code bits) |
| cfg_slow | input | 1 | Slow-timing option |
| bus16 | input | 1 | 1: 16-bit data bus, 0: 8-bit data bus |
| cs_hit | input | 1 | The access decodes into this block's chip-select area |
| req | input | 1 | Access request |
| wr | input | 1 | 1: write, 0: read |
| be_lo | input | 1 | Lower byte enable (16-bit bus) |
| be_hi | input | 1 | Upper byte enable (16-bit bus) |
| addr | input | ADDR_W (24) | CPU byte address |
| wait_cnt | input | WAIT_W (4) | Wait states for this access |
| dram_a | output | DA_W (12) | Multiplexed DRAM address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Single column strobe for the 8-bit bus, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| oe_n | output | 1 | Output enable, active low |
| busy | output | 1 | An access or its precharge is in progress |

## Verification
The bench visits each column length on both bus widths. A split point off by one shows up at once as a wrong row or column address, especially at the all-ones address and at odd addresses. It runs zero wait states and several non-zero counts in both normal and slow timing. An off-by-one in the phase counter, or a slow option applied only to the column phase or only to the precharge, shortens or stretches RAS against the model. It drives byte-enable combinations including none, and requests that are disabled, miss the chip-select area or arrive while busy. A controller that confused the strobe styles, leaked strobes when disabled, or took a new access during precharge is caught there. Pass-through mode is checked with a non-zero high address, so that a multiplexer stuck in split mode cannot hide.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ROW  = 2'd1,
        PH_COL  = 2'd2,
        PH_PRE  = 2'd3
    } phase_e;

    typedef struct packed {
        logic       wr;
        logic       b16;
        logic       be_lo;
        logic       be_hi;
        logic       mux;
        logic [1:0] col_len;
    } acc_ctl_t;

    localparam int unsigned COL_BASE = 8;

    function automatic int unsigned col_bits(input logic [1:0] code);
        return COL_BASE + int'(code);
    endfunction

    function automatic int unsigned row_shift(input logic b16, input logic [1:0] code);
        return col_bits(code) + (b16 ? 1 : 0);
    endfunction

endpackage

// File: rtl/dmx_addr_mux.sv
module dmx_addr_mux
    import dmx_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DA_W   = 12
) (
    input  logic [ADDR_W-1:0] addr_q,
    input  acc_ctl_t          ctl_q,
    input  phase_e            phase,
    output logic [DA_W-1:0]   dram_a
);
    logic [ADDR_W-1:0] row_full;
    logic [ADDR_W-1:0] col_full;
    logic [DA_W-1:0]   col_mask;
    int unsigned       ncol;

    always_comb begin
        ncol     = col_bits(ctl_q.col_len);
        row_full = addr_q >> row_shift(ctl_q.b16, ctl_q.col_len);
        col_full = ctl_q.b16 ? (addr_q >> 1) : addr_q;
        for (int i = 0; i < DA_W; i++) begin
            col_mask[i] = (i < int'(ncol));
        end
    end

    always_comb begin
        dram_a = '0;
        if (phase == PH_ROW || phase == PH_COL) begin
            if (!ctl_q.mux) begin
                dram_a = addr_q[DA_W-1:0];
            end else if (phase == PH_ROW) begin
                dram_a = row_full[DA_W-1:0];
            end else begin
                dram_a = col_full[DA_W-1:0] & col_mask;
            end
        end
    end

endmodule

// File: rtl/dmx_seq.sv
module dmx_seq
    import dmx_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WAIT_W-1:0] waits,
    input  logic              slow,
    output phase_e            phase
);
    localparam int CNT_W = WAIT_W + 1;

    logic [WAIT_W-1:0] waits_q;
    logic              slow_q;
    logic [CNT_W-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            waits_q <= '0;
            slow_q  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase   <= PH_ROW;
                        waits_q <= waits;
                        slow_q  <= slow;
                    end
                end
                PH_ROW: begin
                    phase <= PH_COL;
                    cnt   <= {1'b0, waits_q} + CNT_W'(slow_q);
                end
                PH_COL: begin
                    if (cnt == '0) begin
                        phase <= PH_PRE;
                        cnt   <= CNT_W'(slow_q);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_PRE: begin
                    if (cnt == '0) begin
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dmx_strobe.sv
module dmx_strobe
    import dmx_pkg::*;
(
    input  phase_e   phase,
    input  acc_ctl_t ctl_q,
    output logic     ras_n,
    output logic     cas_n,
    output logic     lcas_n,
    output logic     ucas_n,
    output logic     we_n,
    output logic     oe_n
);
    logic col_ph;

    always_comb begin
        col_ph = (phase == PH_COL);
        ras_n  = !(phase == PH_ROW || col_ph);
        cas_n  = !(col_ph && !ctl_q.b16);
        lcas_n = !(col_ph && ctl_q.b16 && ctl_q.be_lo);
        ucas_n = !(col_ph && ctl_q.b16 && ctl_q.be_hi);
        we_n   = !(col_ph && ctl_q.wr);
        oe_n   = !(col_ph && !ctl_q.wr);
    end

endmodule

// File: rtl/dmx_ctrl.sv
module dmx_ctrl
    import dmx_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DA_W   = 12,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic              cfg_mux_en,
    input  logic [1:0]        cfg_col_len,
    input  logic              cfg_slow,
    input  logic              bus16,
    input  logic              cs_hit,
    input  logic              req,
    input  logic              wr,
    input  logic              be_lo,
    input  logic              be_hi,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WAIT_W-1:0] wait_cnt,
    output logic [DA_W-1:0]   dram_a,
    output logic              ras_n,
    output logic              cas_n,
    output logic              lcas_n,
    output logic              ucas_n,
    output logic              we_n,
    output logic              oe_n,
    output logic              busy
);
    phase_e            phase;
    logic              start;
    logic [ADDR_W-1:0] addr_q;
    acc_ctl_t          ctl_q;

    assign start = (phase == PH_IDLE) && req && cs_hit && cfg_en;
    assign busy  = (phase != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            ctl_q  <= '0;
        end else if (start) begin
            addr_q        <= addr;
            ctl_q.wr      <= wr;
            ctl_q.b16     <= bus16;
            ctl_q.be_lo   <= be_lo;
            ctl_q.be_hi   <= be_hi;
            ctl_q.mux     <= cfg_mux_en;
            ctl_q.col_len <= cfg_col_len;
        end
    end

    dmx_seq #(.WAIT_W(WAIT_W)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .waits (wait_cnt),
        .slow  (cfg_slow),
        .phase (phase)
    );

    dmx_addr_mux #(.ADDR_W(ADDR_W), .DA_W(DA_W)) u_amux (
        .addr_q (addr_q),
        .ctl_q  (ctl_q),
        .phase  (phase),
        .dram_a (dram_a)
    );

    dmx_strobe u_strb (
        .phase  (phase),
        .ctl_q  (ctl_q),
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .lcas_n (lcas_n),
        .ucas_n (ucas_n),
        .we_n   (we_n),
        .oe_n   (oe_n)
    );

endmodule

// File: rtl/dmx_ctrl_chk.sv
module dmx_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic ras_n,
    input logic cas_n,
    input logic lcas_n,
    input logic ucas_n,
    input logic we_n,
    input logic oe_n,
    input logic busy
);
    logic any_cas;
    assign any_cas = !cas_n || !lcas_n || !ucas_n;

    AST_CAS_NEEDS_RAS: assert property (@(posedge clk) disable iff (rst)
        any_cas |-> !ras_n); // R3

    AST_RAS_LEADS_CAS: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (!any_cas && we_n && oe_n)); // R3

    AST_ONE_STROBE_STYLE: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> (lcas_n && ucas_n)); // R6

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !oe_n)); // R7

    AST_PRECHARGE_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (busy && !any_cas && we_n && oe_n)); // R9

    AST_RAS_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> busy); // R11

endmodule

bind dmx_ctrl dmx_ctrl_chk u_chk (.*);

// File: tb/dmx_ctrl_tb.sv
`timescale 1ns/1ps
module dmx_ctrl_tb;
    localparam int AW = 24;
    localparam int DW = 12;
    localparam int WW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_en = 0, cfg_mux_en = 1, cfg_slow = 0, bus16 = 0, cs_hit = 0;
    logic req = 0, wr = 0, be_lo = 0, be_hi = 0;
    logic [1:0]    cfg_col_len = 0;
    logic [AW-1:0] addr = 0;
    logic [WW-1:0] wait_cnt = 0;
    logic [DW-1:0] dram_a;
    logic ras_n, cas_n, lcas_n, ucas_n, we_n, oe_n, busy;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_tag = "R1";

    always #2 clk = ~clk;

    dmx_ctrl u_dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_mux_en(cfg_mux_en),
        .cfg_col_len(cfg_col_len), .cfg_slow(cfg_slow), .bus16(bus16),
        .cs_hit(cs_hit), .req(req), .wr(wr), .be_lo(be_lo), .be_hi(be_hi),
        .addr(addr), .wait_cnt(wait_cnt), .dram_a(dram_a), .ras_n(ras_n),
        .cas_n(cas_n), .lcas_n(lcas_n), .ucas_n(ucas_n), .we_n(we_n),
        .oe_n(oe_n), .busy(busy)
    );

    // Reference model: a cycle index k within the access (0 means idle).
    int     k = 0, t_col = 0, t_pre = 0;
    longint m_addr = 0;
    int     m_wr = 0, m_b16 = 0, m_lo = 0, m_hi = 0, m_mux = 0, m_cl = 0;

    always @(posedge clk) begin
        if (rst) begin
            k = 0;
        end else if (k == 0) begin
            if (req && cs_hit && cfg_en) begin
                k = 1;
                m_addr = longint'(addr);
                m_wr = wr; m_b16 = bus16; m_lo = be_lo; m_hi = be_hi;
                m_mux = cfg_mux_en; m_cl = cfg_col_len;
                t_col = 1 + int'(wait_cnt) + (cfg_slow ? 1 : 0);
                t_pre = 1 + (cfg_slow ? 1 : 0);
            end
        end else if (k < 1 + t_col + t_pre) begin
            k = k + 1;
        end else begin
            k = 0;
        end
    end

    task automatic chk(string sig, string tag, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: actual %0h expected %0h", tag, sig, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        int ph;
        longint ea;
        string atag;
        if (k == 0) ph = 0;
        else if (k == 1) ph = 1;
        else if (k <= 1 + t_col) ph = 2;
        else ph = 3;
        ea = 0;
        if (ph == 1 || ph == 2) begin
            if (m_mux == 0) ea = m_addr & 'hFFF;
            else if (ph == 1) ea = (m_addr >> (8 + m_cl + m_b16)) & 'hFFF;
            else ea = (m_addr >> m_b16) & ((longint'(1) << (8 + m_cl)) - 1);
        end
        atag = (m_mux == 0) ? "R10" : (m_b16 != 0 ? "R5" : "R4");
        if (rst || cur_tag == "R1") atag = cur_tag;
        chk("dram_a", atag, longint'(dram_a), ea);
        chk("ras_n", {cur_tag, " R3"}, longint'(ras_n), (ph == 1 || ph == 2) ? 0 : 1);
        chk("cas_n", {cur_tag, " R6 R8"}, longint'(cas_n), (ph == 2 && m_b16 == 0) ? 0 : 1);
        chk("lcas_n", {cur_tag, " R6"}, longint'(lcas_n), (ph == 2 && m_b16 != 0 && m_lo != 0) ? 0 : 1);
        chk("ucas_n", {cur_tag, " R6"}, longint'(ucas_n), (ph == 2 && m_b16 != 0 && m_hi != 0) ? 0 : 1);
        chk("we_n", {cur_tag, " R7"}, longint'(we_n), (ph == 2 && m_wr != 0) ? 0 : 1);
        chk("oe_n", {cur_tag, " R7"}, longint'(oe_n), (ph == 2 && m_wr == 0) ? 0 : 1);
        chk("busy", {cur_tag, " R9"}, longint'(busy), (ph != 0) ? 1 : 0);
    end

    task automatic acc(string tag, logic [AW-1:0] a, logic w, logic b16,
                       logic lo, logic hi, logic [WW-1:0] nw, logic [1:0] cl,
                       logic sl, logic mx, logic cs, logic en, int hold);
        @(posedge clk); #1;
        cur_tag = tag;
        addr = a; wr = w; bus16 = b16; be_lo = lo; be_hi = hi; wait_cnt = nw;
        cfg_col_len = cl; cfg_slow = sl; cfg_mux_en = mx; cs_hit = cs; cfg_en = en;
        req = 1'b1;
        repeat (hold) @(posedge clk);
        #1;
        req = 1'b0;
        // change configuration mid-access: must not disturb the latched access
        cfg_col_len = ~cl; bus16 = ~b16; wr = ~w; cfg_slow = ~sl; wait_cnt = ~nw;
        repeat (40) @(posedge clk);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cur_tag = "R1";
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        repeat (2) @(posedge clk);
        // R4 R8: 8-bit reads across every column length and wait counts
        for (int cl = 0; cl < 4; cl++) begin
            acc("R4", 24'hA5C3E7, 0, 0, 0, 0, 4'(cl), 2'(cl), 0, 1, 1, 1, 1);
            acc("R8", 24'hFFFFFF, 1, 0, 0, 0, 4'(3 - cl), 2'(cl), 0, 1, 1, 1, 1);
        end
        // R5 R6 R7: 16-bit writes and reads with byte-enable combinations
        for (int cl = 0; cl < 4; cl++) begin
            acc("R5", 24'h3B1F29, 1, 1, 1, 1, 4'd1, 2'(cl), 0, 1, 1, 1, 1);
            acc("R6", 24'h800001, 0, 1, 1'(cl), 1'(cl >> 1), 4'd0, 2'(cl), 0, 1, 1, 1, 1);
        end
        acc("R7", 24'h5A5A5A, 1, 0, 0, 0, 4'd2, 2'd1, 0, 1, 1, 1, 1);
        // R8 R9: slow timing
        acc("R9", 24'h123456, 0, 0, 0, 0, 4'd0, 2'd2, 1, 1, 1, 1, 1);
        acc("R9", 24'hFEDCBA, 1, 1, 1, 0, 4'd5, 2'd3, 1, 1, 1, 1, 1);
        acc("R8", 24'h0F0F0F, 0, 1, 0, 1, 4'd15, 2'd0, 1, 1, 1, 1, 1);
        // R10: pass-through address
        acc("R10", 24'hABCDEF, 0, 0, 0, 0, 4'd1, 2'd2, 0, 0, 1, 1, 1);
        acc("R10", 24'h987654, 1, 1, 1, 1, 4'd0, 2'd0, 1, 0, 1, 1, 1);
        // R2: disabled or outside the chip-select area
        acc("R2", 24'h111111, 1, 0, 0, 0, 4'd1, 2'd0, 0, 1, 1, 0, 3);
        acc("R2", 24'h222222, 0, 1, 1, 1, 4'd1, 2'd1, 0, 1, 0, 1, 3);
        // R11: request held across busy, re-accepted only after precharge
        acc("R11", 24'h333333, 1, 0, 0, 0, 4'd2, 2'd1, 0, 1, 1, 1, 12);
        acc("R11", 24'h444444, 0, 1, 1, 1, 4'd1, 2'd3, 1, 1, 1, 1, 20);
        // R1: reset in the middle of an access
        @(posedge clk); #1;
        cur_tag = "R1"; cfg_en = 1; cs_hit = 1; req = 1; cfg_slow = 0; wait_cnt = 4'd6;
        repeat (3) @(posedge clk);
        #1 rst = 1'b1; req = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        repeat (3) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule